// File: doc/BRIEF.md
# Embedded Operation Status Word Generator

This block sits on the read path of a flash-style memory controller. While an embedded program or erase runs, reads do not return array contents; they return a status word whose bits tell software the state of the operation: a polarity bit that shows the inverse of the programmed data until programming completes, a bit that flips on every read while the part is busy, a time-limit flag, a bit that marks whether erase has left its sector-collection window, and a bit that flips only for reads that hit a sector chosen for erase. The block also drives a registered ready/busy level.

The command decoder supplies the current phase, a one-cycle pulse when a new embedded operation starts, a timeout flag, the last programmed data byte and whether the read address lies in an erase-selected sector. On each read strobe the block either forwards the array data or builds the status word. It registers the result and holds it until the next strobe. It owns the two toggle flip-flops behind the flipping bits.

Top module: `emb_status_gen`

## Requirements
- R1: While `rst` is high and after it is released, `rd_data` is 0, `ready` is 1 and both toggle bits are cleared. The first busy-phase status read after reset shows bit 6 = 0 and bit 2 = 0.
- R2: A read result appears on `rd_data` on the clock edge that samples `rd_stb` high. It is held unchanged while `rd_stb` stays low, whatever the other inputs do.
- R3: In the idle phase (code 0), the done phase (code 6) and the unused code 7, a read returns `array_data` unchanged.
- R4: In the program phase (code 1) and the suspend-program phase (code 5), status bit 7 is the inverse of `prog_data[7]`, bit 6 is the busy toggle, bit 5 is the timeout flag, and all other bits are 0.
- R5: Bit 6 inverts after every read taken in a busy phase (codes 1, 2, 3, 5). No other read changes it. When the read returns array data, bit 6 therefore no longer alternates.
- R6: In a busy phase, status bit 5 equals `time_exceeded`. Bits 6 and 2 keep toggling while it is set. In the suspend phase, bit 5 is 0.
- R7: In the erase-collection window (code 2), bit 3 is 0. In the active-erase phase (code 3), bit 3 is 1. Bit 7 is 0 in both. Bit 2 shows the sector toggle, and bits 4, 1 and 0 are 0.
- R8: The sector toggle (bit 2) inverts only after a read with `in_erase_sector`=1 in codes 2, 3 or 4. A read with `in_erase_sector`=0 leaves it unchanged.
- R9: In the erase-suspend phase (code 4), a read with `in_erase_sector`=1 returns bit 7 = 1, bit 6 frozen, bit 2 toggling and all other bits 0. A read with `in_erase_sector`=0 returns `array_data`.
- R10: `ready` is 0 one cycle after the phase is 1, 2, 3 or 5, and 1 one cycle after any other phase.
- R11: A cycle with `op_start`=1 clears both toggle bits. A status read made after that pulse shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 3 | Operation phase: 0 idle, 1 program, 2 erase window, 3 erasing, 4 erase suspended, 5 suspend program, 6 done |
| op_start | input | 1 | One-cycle pulse when a new embedded operation begins |
| time_exceeded | input | 1 | Operation has run past its time limit |
| prog_data | input | 8 | Last data byte written by a program command |
| in_erase_sector | input | 1 | Read address lies in a sector selected for erase |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| array_data | input | DATA_W | Data read from the array |
| rd_data | output | DATA_W | Registered read result |
| ready | output | 1 | Registered ready (1) / busy (0) level |

## Verification
The toggle state is visible only through the sequence of reads. A toggle that advances on the wrong reads, or fails to clear on a new operation, shows up as a wrong bit 6 or bit 2 on the very next status read. The bench therefore walks phase sequences and predicts every word from the read history, including reads outside the erase sector that must leave bit 2 alone. A wrong phase decode shows at once on bits 7, 5 or 3 of the next read, or on `ready` one cycle after the phase changes.

// File: rtl/emb_status_pkg.sv
package emb_status_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_PROG      = 3'd1,
    PH_ERASE_WIN = 3'd2,
    PH_ERASING   = 3'd3,
    PH_SUSP      = 3'd4,
    PH_SUSP_PROG = 3'd5,
    PH_DONE      = 3'd6,
    PH_SPARE     = 3'd7
  } op_phase_t;

  localparam int BIT_POLL   = 7;
  localparam int BIT_BUSYTG = 6;
  localparam int BIT_TMO    = 5;
  localparam int BIT_ERSTRT = 3;
  localparam int BIT_SECTG  = 2;
  localparam int STAT_W     = 8;

  function automatic logic phase_busy(input op_phase_t p);
    return (p == PH_PROG) || (p == PH_ERASE_WIN) ||
           (p == PH_ERASING) || (p == PH_SUSP_PROG);
  endfunction

  function automatic logic phase_sec_track(input op_phase_t p);
    return (p == PH_ERASE_WIN) || (p == PH_ERASING) || (p == PH_SUSP);
  endfunction

endpackage

// File: rtl/emb_toggle_cell.sv
module emb_toggle_cell (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (adv)   q <= ~q;
  end
endmodule

// File: rtl/emb_ready_gen.sv
module emb_ready_gen
  import emb_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  op_phase_t ph,
  output logic      ready
);
  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b1;
    else     ready <= ~phase_busy(ph);
  end
endmodule

// File: rtl/emb_status_compose.sv
module emb_status_compose
  import emb_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_phase_t         ph,
  input  logic              tmo,
  input  logic              pd_msb,
  input  logic              in_sec,
  input  logic              tg_busy,
  input  logic              tg_sec,
  input  logic [DATA_W-1:0] arr,
  output logic [DATA_W-1:0] word
);
  logic [STAT_W-1:0] stat;
  logic              use_stat;

  always_comb begin
    stat     = '0;
    use_stat = 1'b1;
    unique case (ph)
      PH_PROG, PH_SUSP_PROG: begin
        stat[BIT_POLL]   = ~pd_msb;
        stat[BIT_BUSYTG] = tg_busy;
        stat[BIT_TMO]    = tmo;
      end
      PH_ERASE_WIN, PH_ERASING: begin
        stat[BIT_BUSYTG] = tg_busy;
        stat[BIT_TMO]    = tmo;
        stat[BIT_ERSTRT] = (ph == PH_ERASING);
        stat[BIT_SECTG]  = tg_sec;
      end
      PH_SUSP: begin
        use_stat         = in_sec;
        stat[BIT_POLL]   = 1'b1;
        stat[BIT_BUSYTG] = tg_busy;
        stat[BIT_SECTG]  = tg_sec;
      end
      default: use_stat = 1'b0;
    endcase
  end

  generate
    if (DATA_W > STAT_W) begin : g_wide
      assign word = use_stat ? {{(DATA_W-STAT_W){1'b0}}, stat} : arr;
    end else begin : g_narrow
      assign word = use_stat ? stat[DATA_W-1:0] : arr;
    end
  endgenerate
endmodule

// File: rtl/emb_status_gen.sv
module emb_status_gen
  import emb_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        phase,
  input  logic              op_start,
  input  logic              time_exceeded,
  input  logic [7:0]        prog_data,
  input  logic              in_erase_sector,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  op_phase_t         ph;
  logic              tg_busy, tg_sec;
  logic              adv_busy, adv_sec;
  logic [DATA_W-1:0] word;
  logic              unused_pd;

  assign ph        = op_phase_t'(phase);
  assign unused_pd = ^prog_data[6:0];
  assign adv_busy  = rd_stb && phase_busy(ph);
  assign adv_sec   = rd_stb && in_erase_sector && phase_sec_track(ph);

  emb_toggle_cell u_tg_busy (
    .clk(clk), .rst(rst), .clr(op_start), .adv(adv_busy), .q(tg_busy)
  );

  emb_toggle_cell u_tg_sec (
    .clk(clk), .rst(rst), .clr(op_start), .adv(adv_sec), .q(tg_sec)
  );

  emb_status_compose #(.DATA_W(DATA_W)) u_compose (
    .ph(ph), .tmo(time_exceeded), .pd_msb(prog_data[7]),
    .in_sec(in_erase_sector), .tg_busy(tg_busy), .tg_sec(tg_sec),
    .arr(array_data), .word(word)
  );

  emb_ready_gen u_ready (
    .clk(clk), .rst(rst), .ph(ph), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_stb) rd_data <= word;
  end
endmodule

// File: rtl/emb_status_chk.sv
module emb_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        phase,
  input logic              op_start,
  input logic              time_exceeded,
  input logic [7:0]        prog_data,
  input logic              in_erase_sector,
  input logic              rd_stb,
  input logic [DATA_W-1:0] array_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              ready
);
  logic busy_ph;
  assign busy_ph = (phase == 3'd1) || (phase == 3'd2) ||
                   (phase == 3'd3) || (phase == 3'd5);

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R3
  a_r3_array_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (phase == 3'd0 || phase == 3'd6)) |=> rd_data == $past(array_data));

  // R4
  a_r4_poll_inv: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (phase == 3'd1 || phase == 3'd5)) |=> rd_data[7] == ~$past(prog_data[7]));

  // R6
  a_r6_tmo: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy_ph) |=> rd_data[5] == $past(time_exceeded));

  // R7
  a_r7_erase_start: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (phase == 3'd2 || phase == 3'd3)) |=>
      (rd_data[3] == ($past(phase) == 3'd3)) && !rd_data[7]);

  // R9
  a_r9_susp_sec: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && phase == 3'd4 && in_erase_sector) |=> rd_data[7] && !rd_data[5]);

  // R10
  a_r10_ready: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ready == !$past(busy_ph));

  // R1
  always @(posedge clk) begin
    if (!rst && $past(rst)) begin
      a_r1_reset_out: assert (rd_data == '0 && ready);
    end
  end
endmodule

bind emb_status_gen emb_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/emb_status_gen_tb.sv
module emb_status_gen_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    phase;
  logic          op_start;
  logic          time_exceeded;
  logic [7:0]    prog_data;
  logic          in_erase_sector;
  logic          rd_stb;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic          ready;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  emb_status_gen #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .phase(phase), .op_start(op_start),
    .time_exceeded(time_exceeded), .prog_data(prog_data),
    .in_erase_sector(in_erase_sector), .rd_stb(rd_stb),
    .array_data(array_data), .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic start_op(input logic [2:0] ph);
    @(negedge clk); phase = ph; op_start = 1'b1;
    @(negedge clk); op_start = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; phase = 3'd0; op_start = 0; time_exceeded = 0;
    prog_data = 0; in_erase_sector = 0; rd_stb = 0; array_data = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 ready after reset", ready, 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after release", ready, 1);
  endtask

  task automatic t_idle_hold;
    array_data = 8'h96; rd("R3 idle array", 8'h96);
    array_data = 8'h11; phase = 3'd7;
    repeat (3) @(negedge clk);
    chk("R2 held without strobe", rd_data, 8'h96);
    rd("R3 spare code array", 8'h11);
    phase = 3'd0;
  endtask

  task automatic t_program;
    prog_data = 8'h80;
    start_op(3'd1);
    chk("R10 ready low in program", ready, 0);
    rd("R4 R5 prog read1", 8'h00);
    rd("R5 prog read2", 8'h40);
    rd("R5 prog read3", 8'h00);
    time_exceeded = 1'b1;
    rd("R6 prog timeout read1", 8'h60);
    rd("R6 prog timeout read2", 8'h20);
    time_exceeded = 1'b0;
    @(negedge clk); phase = 3'd6; array_data = 8'h5A;
    @(negedge clk);
    chk("R10 ready high when done", ready, 1);
    rd("R3 done read1", 8'h5A);
    rd("R5 done no toggle", 8'h5A);
  endtask

  task automatic t_restart;
    prog_data = 8'h7F;
    start_op(3'd1);
    rd("R4 prog msb0 read1", 8'h80);
    rd("R5 prog msb0 read2", 8'hC0);
    start_op(3'd1);
    rd("R11 toggle cleared by start", 8'h80);
  endtask

  task automatic t_erase;
    in_erase_sector = 1'b1;
    start_op(3'd2);
    chk("R10 ready low in window", ready, 0);
    rd("R1 R11 window read1", 8'h00);
    rd("R7 R8 window read2", 8'h44);
    in_erase_sector = 1'b0;
    rd("R8 window outside sector", 8'h00);
    in_erase_sector = 1'b1;
    rd("R8 sector bit not advanced", 8'h40);
    phase = 3'd3;
    rd("R7 erasing read1", 8'h0C);
    rd("R7 erasing read2", 8'h48);
    @(negedge clk); phase = 3'd4;
    @(negedge clk);
    chk("R10 ready high in suspend", ready, 1);
    rd("R9 suspend sector read1", 8'h84);
    rd("R9 suspend sector read2", 8'h80);
    in_erase_sector = 1'b0; array_data = 8'h3C;
    rd("R9 suspend other sector", 8'h3C);
    phase = 3'd5; prog_data = 8'h00;
    @(negedge clk);
    chk("R10 ready low in suspend program", ready, 0);
    rd("R4 suspend program read1", 8'h80);
    rd("R5 suspend program read2", 8'hC0);
    phase = 3'd3; in_erase_sector = 1'b1; time_exceeded = 1'b1;
    rd("R6 erase timeout read1", 8'h2C);
    rd("R6 erase timeout read2", 8'h68);
    time_exceeded = 1'b0; phase = 3'd0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle_hold();
    t_program();
    t_restart();
    t_erase();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule